// File: doc/BRIEF.md
# Serial Configuration Memory Sweep Reader

This block fetches the whole contents of a small three-wire serial configuration memory (64 words of 16 bits) right after reset. It drives the serial clock, chip select and command data lines, and collects the returned data line itself. Each word it fetches appears for one cycle on a write port, so a neighbouring register array can store the word without further logic.

As the words go by, the block keeps a 16-bit running sum. When the last address has been read, it raises a one-cycle done pulse. A validity flag comes up at the same time when the sum matches the expected constant. The first three words are also turned into a 48-bit station address in transmission byte order. A synchronous start input abandons any sweep in progress and begins again from address zero. The serial clock half-period is a parameter counted in system-clock cycles, so the interface can be held near one microsecond per line change at any system clock frequency.

Top module: `serial_cfg_reader`

## Requirements
- R1: After reset is released, and after a start pulse, `mem_cs`, `mem_sk` and `mem_di` stay low for one half-period (HALF_CYC cycles). Reading of address 0 then begins without any further request.
- R2: A word read raises `mem_cs` and shifts out a 9-bit command MSB first: a start bit 1, the read opcode bits 1 then 0, and the 6-bit address MSB first. For each bit, `mem_di` is set while `mem_sk` is low for one half-period. `mem_sk` is then high for one half-period with `mem_di` unchanged.
- R3: Sixteen data bits follow, MSB first. For each bit, `mem_sk` is low for one half-period and then high for one half-period. `mem_do` is sampled at the end of the high half-period, and `mem_di` is held low throughout.
- R4: After the last data bit, `mem_cs`, `mem_sk` and `mem_di` are all low for one half-period before the next word begins. `mem_sk` and `mem_di` are never high while `mem_cs` is low.
- R5: Once set, every level on the three driven serial lines is held for at least HALF_CYC cycles, except when a start pulse cuts it short.
- R6: Addresses are read in ascending order from 0 to 63. Each word gives a one-cycle `wr_en` with `wr_addr` and `wr_data`, in the cycle where its trailing low period begins.
- R7: `done` is a one-cycle pulse, raised at the end of the trailing low period of word 63. From that cycle on, `busy` is low until the next start.
- R8: `valid` rises together with `done` only if the 16-bit wrapping sum of all 64 words equals 0xBABA, and otherwise stays low. It stays high until a start pulse or reset.
- R9: `station_addr` holds byte n in bits [47-8n -: 8]. Byte 2k is the low byte of word k and byte 2k+1 is its high byte, for k from 0 to 2.
- R10: A start pulse during a sweep drops the serial lines low and clears `valid`. The sweep then restarts at address 0 with the sum cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart of the sweep |
| mem_do | input | 1 | Serial data returned by the memory |
| mem_sk | output | 1 | Serial clock to the memory |
| mem_cs | output | 1 | Chip select to the memory |
| mem_di | output | 1 | Serial command data to the memory |
| wr_en | output | 1 | One-cycle strobe for each fetched word |
| wr_addr | output | 6 | Word address of the strobed word |
| wr_data | output | 16 | Fetched word |
| done | output | 1 | End-of-sweep pulse |
| valid | output | 1 | Checksum matched on the last sweep |
| busy | output | 1 | Sweep in progress |
| station_addr | output | 48 | Station address from words 0 to 2 |

## Verification
The hardest situation to reach is a restart that cuts across a half-period, a command bit or a data bit in the middle of a sweep. This happens after `valid` has already been set. The bench drives a start pulse a fixed number of cycles into a sweep, which lands in the middle of a word. A behavioural memory model answers on `mem_do` from the address it decodes itself. A timeline model, restarted on every start, predicts the serial lines, the write strobes and the flags on each clock. A corrupted word then runs a sweep with a bad checksum, and restoring the word runs one with a good checksum.

// File: rtl/serial_cfg_reader.sv
module serial_cfg_reader #(
  parameter int HALF_CYC = 100,
  parameter int WORDS = 64,
  parameter logic [15:0] GOOD_SUM = 16'hBABA,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mem_do,
  output logic          mem_sk,
  output logic          mem_cs,
  output logic          mem_di,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  output logic          done,
  output logic          valid,
  output logic          busy,
  output logic [47:0]   station_addr
);
  localparam int CMD_W = 3 + AW;
  localparam int NBITS = CMD_W + 16;
  localparam int IW = $clog2(NBITS);
  localparam int CW = $clog2(HALF_CYC + 1);

  typedef enum logic [1:0] {S_GAP, S_RUN, S_TAIL, S_FIN} st_t;

  st_t             st;
  logic [CW-1:0]   hc;
  logic [IW-1:0]   idx;
  logic            ph;
  logic [AW-1:0]   addr;
  logic [15:0]     sr, sum;

  wire             step_end = (hc == CW'(HALF_CYC - 1));
  wire [CMD_W-1:0] cmd      = {3'b110, addr};
  wire             in_cmd   = (idx < IW'(CMD_W));
  wire             last_bit = (idx == IW'(NBITS - 1));
  wire [15:0]      word     = {sr[14:0], mem_do};

  assign mem_cs  = (st == S_RUN);
  assign mem_sk  = mem_cs & ph;
  assign mem_di  = mem_cs & in_cmd & cmd[CMD_W - 1 - int'(idx)];
  assign busy    = (st != S_FIN);
  assign wr_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP;
      hc <= '0;
      idx <= '0;
      ph <= 1'b0;
      addr <= '0;
      sr <= '0;
      sum <= '0;
      wr_en <= 1'b0;
      wr_data <= '0;
      done <= 1'b0;
      valid <= 1'b0;
      station_addr <= '0;
    end else begin
      wr_en <= 1'b0;
      done <= 1'b0;
      if (start) begin
        st <= S_GAP;
        hc <= '0;
        idx <= '0;
        ph <= 1'b0;
        addr <= '0;
        sum <= '0;
        valid <= 1'b0;
      end else if (st != S_FIN) begin
        hc <= step_end ? '0 : hc + 1'b1;
        if (step_end) begin
          case (st)
            S_GAP: begin
              st <= S_RUN;
              idx <= '0;
              ph <= 1'b0;
            end
            S_RUN: begin
              if (!ph) ph <= 1'b1;
              else begin
                ph <= 1'b0;
                if (!in_cmd) sr <= word;
                if (last_bit) begin
                  st <= S_TAIL;
                  wr_en <= 1'b1;
                  wr_data <= word;
                  sum <= sum + word;
                  for (int k = 0; k < 3; k++)
                    if (addr == AW'(k)) station_addr[47-16*k -: 16] <= {word[7:0], word[15:8]};
                end else begin
                  idx <= idx + 1'b1;
                end
              end
            end
            S_TAIL: begin
              if (addr == AW'(WORDS - 1)) begin
                st <= S_FIN;
                done <= 1'b1;
                valid <= (sum == GOOD_SUM);
              end else begin
                addr <= addr + 1'b1;
                st <= S_RUN;
                idx <= '0;
                ph <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/serial_cfg_reader_chk.sv
module serial_cfg_reader_chk #(
  parameter int HALF_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mem_sk,
  input logic mem_cs,
  input logic mem_di,
  input logic wr_en,
  input logic done,
  input logic valid,
  input logic busy
);
  logic [2:0] lines, prev;
  int         hold;
  logic       seen;

  assign lines = {mem_cs, mem_sk, mem_di};
  wire chg = (lines != prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      hold <= 0;
      seen <= 1'b0;
    end else begin
      prev <= lines;
      if (start) seen <= 1'b0;
      else if (chg) seen <= 1'b1;
      hold <= chg ? 0 : ((hold < HALF_CYC) ? hold + 1 : hold);
    end
  end

  assert_cs_rise_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs) |-> (!mem_sk && mem_di));

  assert_idle_lines_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> (!mem_sk && !mem_di));

  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && chg) |-> (hold >= HALF_CYC - 1));

  assert_write_in_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mem_cs);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_cs));

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> done);

  assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> $past(start));
endmodule

bind serial_cfg_reader serial_cfg_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_sk(mem_sk), .mem_cs(mem_cs),
  .mem_di(mem_di), .wr_en(wr_en), .done(done), .valid(valid), .busy(busy)
);

// File: tb/test_serial_cfg_reader.sv
`timescale 1ns/1ps
module test_serial_cfg_reader;
  localparam int H = 3;
  localparam logic [15:0] GOOD = 16'hBABA;

  logic clk = 0, rst_n = 0, start = 0, mem_do = 0;
  logic mem_sk, mem_cs, mem_di, wr_en, done, valid, busy;
  logic [5:0] wr_addr;
  logic [15:0] wr_data;
  logic [47:0] station_addr;

  serial_cfg_reader #(.HALF_CYC(H)) i_serial_cfg_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_do(mem_do), .mem_sk(mem_sk),
    .mem_cs(mem_cs), .mem_di(mem_di), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .valid(valid), .busy(busy),
    .station_addr(station_addr));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] mem [64];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 25) $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural serial memory
  int dev_n = 0;
  logic [8:0] dev_cmd = 0;
  always @(negedge mem_cs) dev_n = 0;
  always @(posedge mem_sk) begin
    if (mem_cs) begin
      dev_n++;
      if (dev_n <= 9) dev_cmd = {dev_cmd[7:0], mem_di};
      else if (dev_n <= 25)
        mem_do = (dev_cmd[8:6] == 3'b110) ? mem[dev_cmd[5:0]][15 - (dev_n - 10)] : 1'b1;
    end
  end

  // timeline reference model
  logic e_cs = 0, e_sk = 0, e_di = 0, e_wr = 0, e_done = 0, e_valid = 0, e_busy = 1;
  logic [5:0] e_wa = 0;
  logic [15:0] e_wd = 0;
  string tag = "R1 R5";

  task automatic step(input logic c, input logic s, input logic d, input string t, output bit ab);
    e_cs = c; e_sk = s; e_di = d; tag = t; ab = 0;
    for (int i = 0; i < H; i++) begin
      @(posedge clk);
      e_wr = 0;
      if (start) begin ab = 1; return; end
    end
  endtask

  task automatic run_model();
    bit ab;
    logic [15:0] s16 = 0;
    e_busy = 1; e_done = 0;
    step(0, 0, 0, "R1 R5", ab); if (ab) return;
    for (int a = 0; a < 64; a++) begin
      logic [8:0] cmd = {3'b110, 6'(a)};
      for (int b = 8; b >= 0; b--) begin
        step(1, 0, cmd[b], "R2 R5", ab); if (ab) return;
        step(1, 1, cmd[b], "R2 R5", ab); if (ab) return;
      end
      for (int b = 0; b < 16; b++) begin
        step(1, 0, 0, "R3 R5", ab); if (ab) return;
        step(1, 1, 0, "R3 R5", ab); if (ab) return;
      end
      e_wr = 1; e_wa = 6'(a); e_wd = mem[a]; s16 += mem[a];
      step(0, 0, 0, "R4 R5", ab); if (ab) return;
    end
    e_done = 1; e_busy = 0; e_valid = (s16 == GOOD);
    e_cs = 0; e_sk = 0; e_di = 0; tag = "R7";
    forever begin
      @(posedge clk);
      e_done = 0;
      if (start) return;
    end
  endtask

  initial begin
    wait (rst_n);
    forever begin
      run_model();
      e_valid = 0; e_wr = 0; e_done = 0; e_busy = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({mem_cs, mem_sk, mem_di} == {e_cs, e_sk, e_di}, tag, {mem_cs, mem_sk, mem_di}, {e_cs, e_sk, e_di});
      check(wr_en == e_wr, "R6", wr_en, e_wr);
      if (e_wr) check({wr_addr, wr_data} == {e_wa, e_wd}, "R6", {wr_addr, wr_data}, {e_wa, e_wd});
      check(done == e_done, "R7", done, e_done);
      check(busy == e_busy, "R7", busy, e_busy);
      check(valid == e_valid, "R8", valid, e_valid);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check(0, "R7", 0, 1);
  endtask

  initial begin
    logic [15:0] s;
    logic [47:0] exp_sa;
    mem[0] = 16'hFFFF; mem[1] = 16'h0000; mem[2] = 16'hA55A;
    for (int i = 3; i < 63; i++) mem[i] = 16'(i * 16'h1357) ^ 16'h5C3A;
    s = 0;
    for (int i = 0; i < 63; i++) s += mem[i];
    mem[63] = GOOD - s;

    repeat (4) @(negedge clk);
    check({mem_cs, mem_sk, mem_di} == 3'b000, "R1", {mem_cs, mem_sk, mem_di}, 0);
    check({wr_en, done, valid, busy} == 4'b0001, "R1", {wr_en, done, valid, busy}, 4'b0001);
    rst_n = 1;

    wait_done();
    check(valid == 1, "R8", valid, 1);
    exp_sa = {mem[0][7:0], mem[0][15:8], mem[1][7:0], mem[1][15:8], mem[2][7:0], mem[2][15:8]};
    check(station_addr == exp_sa, "R9", station_addr, exp_sa);
    repeat (5) @(negedge clk);
    check(valid == 1 && !busy, "R8", {valid, busy}, 2'b10);

    mem[7] ^= 16'h0040;
    pulse_start();
    check(valid == 0 && busy == 1 && !mem_cs, "R10", {valid, busy, mem_cs}, 3'b010);
    wait_done();
    check(valid == 0, "R8", valid, 0);

    mem[7] ^= 16'h0040;
    pulse_start();
    repeat (2000) @(negedge clk);
    check(busy == 1, "R10", busy, 1);
    pulse_start();
    check({mem_cs, mem_sk, mem_di} == 3'b000, "R10", {mem_cs, mem_sk, mem_di}, 0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (wr_en) begin
        check(wr_addr == 0, "R10", wr_addr, 0);
        break;
      end
    end
    wait_done();
    check(valid == 1, "R10", valid, 1);
    check(station_addr == exp_sa, "R9", station_addr, exp_sa);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule